// File: doc/BRIEF.md
# Branch Resolution and Counter/Link Update Unit

This unit sits after the condition-evaluation stage of a vector-aware branch pipeline. It receives the single merged condition produced by scanning the condition fields, plus the branch option bits and the loop counter. From these it makes the final taken/not-taken decision. It also produces the architectural side effects: the decremented counter, the next fetch address and the link-register write.

All branch instructions handled here are 8 bytes long, because they carry a prefix. The sequential address and the link value are therefore the current address plus 8. Relative targets are measured from the first byte of the prefix.

The counter may be decremented before it is tested. When counter-test mode is selected, the decrement can be suppressed depending on the condition result and an inversion flag. The condition stage may also force a decrement for a masked-out element that it skipped.

A link-update-on-taken option keeps the link register intact when the branch falls through. The logic is combinational into a single output register stage. A valid strobe on the input produces a valid strobe, with the results, one cycle later.

Top module: `branch_outcome`

## Requirements
- R1: When `boNoCtr` (BO[2]) is 0 and no suppression applies, `ctrNew` is `ctrIn` minus 1, wrapping from 0 to all ones. When `boNoCtr` is 1, `ctrNew` equals `ctrIn`.
- R2: `modeSel[1]` = 1 selects counter-test mode. In that mode, with `skipDec` = 0, the decrement is suppressed when `condOk` XOR `ctrInvert` is 1.
- R3: `skipDec` = 1 forces the decrement whenever `boNoCtr` is 0, regardless of counter-test mode.
- R4: `ctrOk` = `boNoCtr` OR ((decremented counter != 0) XOR `boCtrZero`). When `mode32` = 1, only bits 31:0 of the decremented counter take part in the comparison.
- R5: `taken` = `ctrOk` AND `condOk`.
- R6: The offset is `disp` sign-extended, shifted left by 2 and widened to 64 bits. On a taken branch, `nextAddr` is the offset itself when `absFlag` = 1, or `curAddr` plus the offset when `absFlag` = 0.
- R7: On a not-taken branch, `nextAddr` = `curAddr` + 8. `linkVal` is always `curAddr` + 8.
- R8: `linkWe` = `linkFlag` AND (NOT `linkOnTaken` OR `taken`).
- R9: All outputs are registered. `outValid` rises one cycle after `inValid`. When `inValid` is 0, the data outputs hold their previous values. After reset, every output is 0.
- R10: `modeSel[0]` = 1 marks VLSET mode. It is delivered unchanged on `vlsetMode` alongside the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input operands valid this cycle |
| condOk | input | 1 | Merged condition from the scan stage |
| skipDec | input | 1 | Forced decrement request for a skipped element |
| ctrInvert | input | 1 | Counter-test inversion flag |
| boNoCtr | input | 1 | BO[2]: 1 leaves the counter alone |
| boCtrZero | input | 1 | BO[3]: sense of the counter test |
| modeSel | input | 2 | Bit 1 counter-test, bit 0 VLSET |
| mode32 | input | 1 | 32-bit counter comparison |
| ctrIn | input | 64 | Current counter |
| curAddr | input | 64 | Address of the branch prefix |
| disp | input | 14 | Word displacement |
| absFlag | input | 1 | Target is absolute |
| linkFlag | input | 1 | Link write requested |
| linkOnTaken | input | 1 | Write link only when taken |
| outValid | output | 1 | Results valid |
| ctrNew | output | 64 | Updated counter |
| ctrOk | output | 1 | Counter test passed |
| taken | output | 1 | Branch taken |
| nextAddr | output | 64 | Next instruction address |
| linkWe | output | 1 | Link write enable |
| linkVal | output | 64 | Value to write to the link register |
| vlsetMode | output | 1 | VLSET mode carried with the result |

## Verification
Random operand sets exercise all combinations of the option bits together. A reference function covers the decrement gating, the counter test, the branch decision and the target selection.

Directed cases isolate specific behaviours:
- Counter equal to 0 separates a correct 64-bit wrap from a saturating decrement.
- A counter with zero low half but nonzero high half separates a correct 32-bit comparison from a full-width one.
- Counter-test vectors with each `condOk`/`ctrInvert` pairing tell suppression apart from the plain decrement, and also show that `skipDec` overrides suppression.
- Negative displacements in both addressing modes check the sign extension.
- Idle cycles with changed inputs show that the outputs hold.

// File: rtl/branch_outcome_pkg.sv
package branch_outcome_pkg;
  parameter int ADDR_W     = 64;
  parameter int CTR_W      = 64;
  parameter int DISP_W     = 14;
  parameter int INSN_BYTES = 8;
  localparam int HALF_W    = CTR_W / 2;

  typedef struct packed {
    logic load;
    logic decEn;
    logic ctrOk;
    logic taken;
    logic linkWe;
  } brStrobe_t;
endpackage

// File: rtl/branch_outcome_ctrl.sv
module branch_outcome_ctrl
  import branch_outcome_pkg::*;
(
  input  logic      inValid,
  input  logic      condOk,
  input  logic      skipDec,
  input  logic      ctrInvert,
  input  logic      boNoCtr,
  input  logic      boCtrZero,
  input  logic      ctrTestMode,
  input  logic      linkFlag,
  input  logic      linkOnTaken,
  input  logic      ctrNonZero,
  output brStrobe_t strobes
);
  logic suppress;

  always_comb begin
    suppress        = ctrTestMode && (condOk ^ ctrInvert) && !skipDec;
    strobes.load    = inValid;
    strobes.decEn   = !boNoCtr && !suppress;
    strobes.ctrOk   = boNoCtr || (ctrNonZero ^ boCtrZero);
    strobes.taken   = strobes.ctrOk && condOk;
    strobes.linkWe  = linkFlag && (!linkOnTaken || strobes.taken);
  end
endmodule

// File: rtl/branch_outcome_dp.sv
module branch_outcome_dp
  import branch_outcome_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CTR_W,
  parameter int DW = DISP_W,
  parameter int IB = INSN_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  brStrobe_t     strobes,
  input  logic          mode32,
  input  logic          vlsetIn,
  input  logic [CW-1:0] ctrIn,
  input  logic [AW-1:0] curAddr,
  input  logic [DW-1:0] disp,
  input  logic          absFlag,
  output logic          ctrNonZero,
  output logic          outValid,
  output logic [CW-1:0] ctrNew,
  output logic          ctrOk,
  output logic          taken,
  output logic [AW-1:0] nextAddr,
  output logic          linkWe,
  output logic [AW-1:0] linkVal,
  output logic          vlsetMode
);
  localparam int HW  = CW / 2;
  localparam int EXT = AW - DW - 2;

  logic [CW-1:0] ctrNext;
  logic [AW-1:0] offset;
  logic [AW-1:0] seqAddr;
  logic [AW-1:0] target;
  logic [AW-1:0] addrNext;

  always_comb begin
    ctrNext    = ctrIn - CW'(strobes.decEn);
    ctrNonZero = mode32 ? (ctrNext[HW-1:0] != '0) : (ctrNext != '0);
    offset     = {{EXT{disp[DW-1]}}, disp, 2'b00};
    seqAddr    = curAddr + AW'(IB);
    target     = absFlag ? offset : (curAddr + offset);
    addrNext   = strobes.taken ? target : seqAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      ctrNew    <= '0;
      ctrOk     <= 1'b0;
      taken     <= 1'b0;
      nextAddr  <= '0;
      linkWe    <= 1'b0;
      linkVal   <= '0;
      vlsetMode <= 1'b0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        ctrNew    <= ctrNext;
        ctrOk     <= strobes.ctrOk;
        taken     <= strobes.taken;
        nextAddr  <= addrNext;
        linkWe    <= strobes.linkWe;
        linkVal   <= seqAddr;
        vlsetMode <= vlsetIn;
      end
    end
  end
endmodule

// File: rtl/branch_outcome.sv
module branch_outcome
  import branch_outcome_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                condOk,
  input  logic                skipDec,
  input  logic                ctrInvert,
  input  logic                boNoCtr,
  input  logic                boCtrZero,
  input  logic [1:0]          modeSel,
  input  logic                mode32,
  input  logic [CTR_W-1:0]    ctrIn,
  input  logic [ADDR_W-1:0]   curAddr,
  input  logic [DISP_W-1:0]   disp,
  input  logic                absFlag,
  input  logic                linkFlag,
  input  logic                linkOnTaken,
  output logic                outValid,
  output logic [CTR_W-1:0]    ctrNew,
  output logic                ctrOk,
  output logic                taken,
  output logic [ADDR_W-1:0]   nextAddr,
  output logic                linkWe,
  output logic [ADDR_W-1:0]   linkVal,
  output logic                vlsetMode
);
  brStrobe_t strobes;
  logic      ctrNonZero;

  branch_outcome_ctrl u_ctrl (
    .inValid     (inValid),
    .condOk      (condOk),
    .skipDec     (skipDec),
    .ctrInvert   (ctrInvert),
    .boNoCtr     (boNoCtr),
    .boCtrZero   (boCtrZero),
    .ctrTestMode (modeSel[1]),
    .linkFlag    (linkFlag),
    .linkOnTaken (linkOnTaken),
    .ctrNonZero  (ctrNonZero),
    .strobes     (strobes)
  );

  branch_outcome_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .mode32     (mode32),
    .vlsetIn    (modeSel[0]),
    .ctrIn      (ctrIn),
    .curAddr    (curAddr),
    .disp       (disp),
    .absFlag    (absFlag),
    .ctrNonZero (ctrNonZero),
    .outValid   (outValid),
    .ctrNew     (ctrNew),
    .ctrOk      (ctrOk),
    .taken      (taken),
    .nextAddr   (nextAddr),
    .linkWe     (linkWe),
    .linkVal    (linkVal),
    .vlsetMode  (vlsetMode)
  );
endmodule

// File: rtl/branch_outcome_chk.sv
module branch_outcome_chk
  import branch_outcome_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic                condOk,
  input logic                skipDec,
  input logic                ctrInvert,
  input logic                boNoCtr,
  input logic                boCtrZero,
  input logic [1:0]          modeSel,
  input logic                mode32,
  input logic [CTR_W-1:0]    ctrIn,
  input logic [ADDR_W-1:0]   curAddr,
  input logic [DISP_W-1:0]   disp,
  input logic                absFlag,
  input logic                linkFlag,
  input logic                linkOnTaken,
  input logic                outValid,
  input logic [CTR_W-1:0]    ctrNew,
  input logic                ctrOk,
  input logic                taken,
  input logic [ADDR_W-1:0]   nextAddr,
  input logic                linkWe,
  input logic [ADDR_W-1:0]   linkVal,
  input logic                vlsetMode
);
  AST_HOLD_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && boNoCtr |=> ctrNew == $past(ctrIn)); // R1
  AST_PLAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !boNoCtr && !modeSel[1] |=> ctrNew == $past(ctrIn) - 64'd1); // R1
  AST_TEST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !boNoCtr && modeSel[1] && !skipDec && (condOk ^ ctrInvert)
      |=> ctrNew == $past(ctrIn)); // R2
  AST_FORCED_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !boNoCtr && skipDec |=> ctrNew == $past(ctrIn) - 64'd1); // R3
  AST_TAKEN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> taken == (ctrOk && $past(condOk))); // R5
  AST_SEQ_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> linkVal == $past(curAddr) + 64'd8); // R7
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> taken || nextAddr == linkVal); // R7
  AST_LINK_WE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> linkWe == ($past(linkFlag) && (!$past(linkOnTaken) || taken))); // R8
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid && $stable(ctrNew) && $stable(nextAddr)); // R9
  AST_VLSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> vlsetMode == $past(modeSel[0])); // R10
endmodule

bind branch_outcome branch_outcome_chk chk (.*);

// File: tb/branch_outcome_test.sv
`timescale 1ns/1ps
module branch_outcome_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, condOk = 1'b0, skipDec = 1'b0, ctrInvert = 1'b0;
  logic        boNoCtr = 1'b0, boCtrZero = 1'b0, mode32 = 1'b0, absFlag = 1'b0;
  logic        linkFlag = 1'b0, linkOnTaken = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [63:0] ctrIn = '0, curAddr = '0;
  logic [13:0] disp = '0;
  logic        outValid, ctrOk, taken, linkWe, vlsetMode;
  logic [63:0] ctrNew, nextAddr, linkVal;

  int total = 0;
  int bad = 0;

  branch_outcome uut (.*);

  always #2.5 clk = ~clk;

  // Expected results, worked out from the requirements.
  logic [63:0] eCtr, eNext, eLink;
  logic        eOk, eTaken, eWe;

  task automatic compute();
    logic        dec;
    logic        nz;
    logic [63:0] off;
    dec = !boNoCtr && (skipDec || !(modeSel[1] && (condOk ^ ctrInvert)));
    eCtr = dec ? ctrIn - 64'd1 : ctrIn;
    nz = mode32 ? (eCtr[31:0] != 32'd0) : (eCtr != 64'd0);
    eOk = boNoCtr | (nz ^ boCtrZero);
    eTaken = eOk & condOk;
    off = {{48{disp[13]}}, disp, 2'b00};
    eLink = curAddr + 64'd8;
    eNext = eTaken ? (absFlag ? off : curAddr + off) : eLink;
    eWe = linkFlag & (!linkOnTaken | eTaken);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
  task automatic apply();
    compute();
    inValid = 1'b1;
    @(negedge clk);
    check("R9 outValid", 64'(outValid), 64'd1);
    check("R1 ctrNew", ctrNew, eCtr);
    check("R4 ctrOk", 64'(ctrOk), 64'(eOk));
    check("R5 taken", 64'(taken), 64'(eTaken));
    check("R6 nextAddr", nextAddr, eNext);
    check("R7 linkVal", linkVal, eLink);
    check("R8 linkWe", 64'(linkWe), 64'(eWe));
    check("R10 vlsetMode", 64'(vlsetMode), 64'(modeSel[0]));
    inValid = 1'b0;
  endtask

  task automatic setBase();
    condOk = 1'b1; skipDec = 1'b0; ctrInvert = 1'b0; boNoCtr = 1'b0; boCtrZero = 1'b0;
    modeSel = 2'b00; mode32 = 1'b0; absFlag = 1'b0; linkFlag = 1'b1; linkOnTaken = 1'b0;
    ctrIn = 64'd5; curAddr = 64'h1000; disp = 14'd4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [63:0] holdCtr;
    logic [63:0] holdNext;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset outValid", 64'(outValid), 64'd0);
    check("R9 reset ctrNew", ctrNew, 64'd0);
    check("R9 reset nextAddr", nextAddr, 64'd0);
    check("R9 reset linkWe", 64'(linkWe), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 wrap from zero
    setBase(); ctrIn = 64'd0; apply();
    check("R1 wrap", ctrNew, 64'hFFFF_FFFF_FFFF_FFFF);
    // R1 hold with BO[2]
    setBase(); boNoCtr = 1'b1; apply();
    check("R1 no decrement", ctrNew, 64'd5);
    // R4 32-bit: low half reaches zero while high half is not zero
    setBase(); mode32 = 1'b1; ctrIn = 64'h1_0000_0001; apply();
    check("R4 32-bit ctrOk", 64'(ctrOk), 64'd0);
    setBase(); mode32 = 1'b0; ctrIn = 64'h1_0000_0001; apply();
    check("R4 64-bit ctrOk", 64'(ctrOk), 64'd1);
    // R2 counter-test suppression
    setBase(); modeSel = 2'b10; condOk = 1'b1; ctrInvert = 1'b0; apply();
    check("R2 suppressed", ctrNew, 64'd5);
    setBase(); modeSel = 2'b10; condOk = 1'b0; ctrInvert = 1'b0; apply();
    check("R2 decrement on fail", ctrNew, 64'd4);
    setBase(); modeSel = 2'b11; condOk = 1'b0; ctrInvert = 1'b1; apply();
    check("R2 inverted suppressed", ctrNew, 64'd5);
    // R3 forced decrement overrides suppression
    setBase(); modeSel = 2'b10; condOk = 1'b1; skipDec = 1'b1; apply();
    check("R3 forced", ctrNew, 64'd4);
    // R6 negative displacements, both addressing modes
    setBase(); disp = 14'h3FFE; apply();
    check("R6 relative negative", nextAddr, 64'h0FF8);
    setBase(); disp = 14'h2000; absFlag = 1'b1; apply();
    check("R6 absolute negative", nextAddr, 64'hFFFF_FFFF_FFFF_8000);
    // R7 / R8 fall-through with link-on-taken
    setBase(); condOk = 1'b0; linkOnTaken = 1'b1; apply();
    check("R7 fall through", nextAddr, 64'h1008);
    check("R8 link suppressed", 64'(linkWe), 64'd0);

    // R9 idle cycle with changed inputs: outputs hold
    holdCtr = ctrNew; holdNext = nextAddr;
    ctrIn = 64'd77; curAddr = 64'h9999; condOk = 1'b1;
    @(negedge clk);
    check("R9 idle valid", 64'(outValid), 64'd0);
    check("R9 idle ctr hold", ctrNew, holdCtr);
    check("R9 idle addr hold", nextAddr, holdNext);

    // Random mix of all fields
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      condOk = r[0]; skipDec = r[1]; ctrInvert = r[2]; boNoCtr = r[3];
      boCtrZero = r[4]; modeSel = r[6:5]; mode32 = r[7]; absFlag = r[8];
      linkFlag = r[9]; linkOnTaken = r[10]; disp = r[24:11];
      case (r[27:25])
        3'd0: ctrIn = 64'd1;
        3'd1: ctrIn = 64'd0;
        3'd2: ctrIn = {$urandom(), 32'd1};
        default: ctrIn = {$urandom(), $urandom()};
      endcase
      curAddr = {$urandom(), $urandom() & 32'hFFFF_FFFC};
      apply();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule